// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block takes configuration words from a three-wire serial port made of a data line, a serial clock and a load strobe. All three lines are asynchronous to the system clock. They pass through a two-stage synchronizer. Each synchronized rising edge of the serial clock shifts one data bit into a 19-bit shift register. A rising edge of the load strobe then copies the register contents into one of two holding sets.

The bit that arrives last lands in the least significant position and selects the destination. A high selector picks the reference set, which holds an 18-bit word: a 14-bit reference ratio, a modulus-select bit, a phase-polarity bit and a monitor-select bit. A low selector picks the divider set, which holds a 19-bit word: a 7-bit swallow count and an 11-bit main count.

Every held field is presented in parallel. Each set has a one-cycle update strobe that marks a completed write. A write whose ratio or main count is below the legal minimum of 5 is refused, and the block raises a one-cycle error pulse instead.

Top module: `serial_cfg_loader`

## Requirements
- R1: Each synchronized rising edge of `ser_clk_i` shifts `ser_data_i` into the shift register at bit 0 and moves the older bits up by one, so bits are sent most significant first and the final bit sits at bit 0.
- R2: On a load with bit 0 = 1, the reference set takes these fields: ratio = bits 14..1, modulus select = bit 15, polarity = bit 16, monitor select = bit 17.
- R3: On a load with bit 0 = 0, the divider set takes these fields: swallow = bits 7..1, main count = bits 18..8.
- R4: A transfer happens only on a rising edge of `ser_le_i`. Shifting with the strobe low changes no output, and holding the strobe high gives no further transfer.
- R5: The set that was not selected keeps its previous contents.
- R6: Each accepted load pulses exactly one strobe for one cycle: `ref_upd_o` for the reference set, `div_upd_o` for the divider set. The two strobes are never high together.
- R7: A reference load with a ratio below 5 is refused. All four reference fields are kept, `cfg_err_o` pulses for one cycle and no strobe fires. A ratio of exactly 5 is accepted.
- R8: A divider load with a main count below 5 is refused in the same way as R7. Both divider fields are kept, `cfg_err_o` pulses and no strobe fires. A main count of exactly 5 is accepted.
- R9: After reset the ratio is 5, the main count is 5, the swallow count is 0, the three mode bits are 0, and both strobes and the error pulse are low.
- R10: Only the most recent bits count. A reference word ignores bit 18, and bits shifted in before the last 19 have no effect.
- R11: Range ends are accepted: a ratio of 16383, swallow counts of 0 and 127, and a main count of 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_le_i | input | 1 | Load strobe; its rising edge transfers the word |
| ref_ratio_o | output | 14 | Reference ratio |
| mod_sel_o | output | 1 | Prescaler modulus select |
| pd_pol_o | output | 1 | Phase comparator polarity |
| mon_sel_o | output | 1 | Monitor output select |
| ref_upd_o | output | 1 | One-cycle strobe after a reference write |
| swallow_o | output | 7 | Swallow count |
| main_cnt_o | output | 11 | Main count |
| div_upd_o | output | 1 | One-cycle strobe after a divider write |
| cfg_err_o | output | 1 | One-cycle pulse when a load is refused |

## Verification
The bound checker watches several properties on every cycle:
- Held fields change only in a cycle where their own strobe is high.
- The two strobes are never high together, and each lasts one cycle.
- An error pulse never coincides with a strobe.
- The ratio and main count never drop below 5.

These properties cannot show that a field lands at the correct bit position, or that the selector bit picks the intended set. They also cannot show that an illegal word is refused rather than never sent, that bits beyond the word length are dropped, or that a held strobe gives exactly one transfer. The directed scenarios in the bench cover those points by comparing the outputs with words assembled independently in the bench.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned REF_RATIO_W = 14;
  localparam int unsigned SWALLOW_W   = 7;
  localparam int unsigned MAIN_W      = 11;
  localparam int unsigned MIN_RATIO   = 5;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    DST_DIV = 1'b0,
    DST_REF = 1'b1
  } dest_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] lvl_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[s] <= '0;
      else if (s == 0) stg[s] <= pin_i;
      else             stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d <= '0;
    else         lvl_d <= stg[STAGES-1];
  end

  assign lvl_o  = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~lvl_d;
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int unsigned W = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/guarded_latch.sv
module guarded_latch #(
  parameter int unsigned W        = 17,
  parameter int unsigned CHK_LSB  = 0,
  parameter int unsigned CHK_W    = 14,
  parameter int unsigned MIN_VAL  = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         upd_o,
  output logic         err_o
);
  localparam logic [CHK_W-1:0] MIN_C = CHK_W'(MIN_VAL);

  logic legal;
  assign legal = d_i[CHK_LSB +: CHK_W] >= MIN_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= RST_VAL;
      upd_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      upd_o <= wr_i & legal;
      err_o <= wr_i & ~legal;
      if (wr_i && legal) q_o <= d_i;
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned REF_W   = REF_RATIO_W,
  parameter int unsigned SWL_W   = SWALLOW_W,
  parameter int unsigned MAIN_CW = MAIN_W,
  parameter int unsigned MIN_R   = MIN_RATIO,
  parameter int unsigned STAGES  = SYNC_STAGES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ser_data_i,
  input  logic               ser_clk_i,
  input  logic               ser_le_i,
  output logic [REF_W-1:0]   ref_ratio_o,
  output logic               mod_sel_o,
  output logic               pd_pol_o,
  output logic               mon_sel_o,
  output logic               ref_upd_o,
  output logic [SWL_W-1:0]   swallow_o,
  output logic [MAIN_CW-1:0] main_cnt_o,
  output logic               div_upd_o,
  output logic               cfg_err_o
);
  localparam int unsigned REF_PAY = REF_W + 3;
  localparam int unsigned DIV_PAY = SWL_W + MAIN_CW;
  localparam int unsigned SR_W    = ((REF_PAY > DIV_PAY) ? REF_PAY : DIV_PAY) + 1;

  localparam logic [REF_PAY-1:0] REF_RST = REF_PAY'(MIN_R);
  localparam logic [DIV_PAY-1:0] DIV_RST = DIV_PAY'(MIN_R) << SWL_W;

  logic [2:0] pin_lvl, pin_rise;
  logic [SR_W-1:0] sr;
  dest_e dest;
  logic ref_wr, div_wr, ref_err, div_err;
  logic [REF_PAY-1:0] ref_q;
  logic [DIV_PAY-1:0] div_q;

  pin_sync #(.N(3), .STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({ser_le_i, ser_clk_i, ser_data_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise)
  );

  word_shifter #(.W(SR_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (pin_rise[1]),
    .bit_i   (pin_lvl[0]),
    .word_o  (sr)
  );

  // selector is the last bit received
  assign dest   = dest_e'(sr[0]);
  assign ref_wr = pin_rise[2] && (dest == DST_REF);
  assign div_wr = pin_rise[2] && (dest == DST_DIV);

  guarded_latch #(
    .W(REF_PAY), .CHK_LSB(0), .CHK_W(REF_W), .MIN_VAL(MIN_R), .RST_VAL(REF_RST)
  ) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ref_wr),
    .d_i    (sr[REF_PAY:1]),
    .q_o    (ref_q),
    .upd_o  (ref_upd_o),
    .err_o  (ref_err)
  );

  guarded_latch #(
    .W(DIV_PAY), .CHK_LSB(SWL_W), .CHK_W(MAIN_CW), .MIN_VAL(MIN_R), .RST_VAL(DIV_RST)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (div_wr),
    .d_i    (sr[DIV_PAY:1]),
    .q_o    (div_q),
    .upd_o  (div_upd_o),
    .err_o  (div_err)
  );

  assign ref_ratio_o = ref_q[REF_W-1:0];
  assign mod_sel_o   = ref_q[REF_W];
  assign pd_pol_o    = ref_q[REF_W+1];
  assign mon_sel_o   = ref_q[REF_W+2];
  assign swallow_o   = div_q[SWL_W-1:0];
  assign main_cnt_o  = div_q[DIV_PAY-1:SWL_W];
  assign cfg_err_o   = ref_err | div_err;
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk #(
  parameter int unsigned REF_W   = 14,
  parameter int unsigned SWL_W   = 7,
  parameter int unsigned MAIN_CW = 11,
  parameter int unsigned MIN_R   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [REF_W-1:0]   ref_ratio_o,
  input logic               mod_sel_o,
  input logic               pd_pol_o,
  input logic               mon_sel_o,
  input logic               ref_upd_o,
  input logic [SWL_W-1:0]   swallow_o,
  input logic [MAIN_CW-1:0] main_cnt_o,
  input logic               div_upd_o,
  input logic               cfg_err_o
);
  // R5
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_upd_o |-> $stable({ref_ratio_o, mod_sel_o, pd_pol_o, mon_sel_o}));
  // R5
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_upd_o |-> $stable({swallow_o, main_cnt_o}));
  // R6
  one_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_upd_o && div_upd_o));
  // R6
  ref_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_upd_o |=> !ref_upd_o);
  // R6
  div_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_upd_o |=> !div_upd_o);
  // R7
  err_no_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !ref_upd_o && !div_upd_o);
  // R7
  ratio_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ratio_o >= REF_W'(MIN_R));
  // R8
  main_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_cnt_o >= MAIN_CW'(MIN_R));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
  .REF_W(REF_W), .SWL_W(SWL_W), .MAIN_CW(MAIN_CW), .MIN_R(MIN_R)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .ref_ratio_o(ref_ratio_o), .mod_sel_o(mod_sel_o), .pd_pol_o(pd_pol_o),
  .mon_sel_o(mon_sel_o), .ref_upd_o(ref_upd_o), .swallow_o(swallow_o),
  .main_cnt_o(main_cnt_o), .div_upd_o(div_upd_o), .cfg_err_o(cfg_err_o)
);

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, sle = 1'b0;
  logic [13:0] ratio;
  logic mod_sel, pol, mon;
  logic ref_upd, div_upd, err;
  logic [6:0] swl;
  logic [10:0] mainc;

  int n_chk = 0, n_bad = 0;
  int ref_cnt = 0, div_cnt = 0, err_cnt = 0;

  always #2.5 clk = ~clk;

  serial_cfg_loader uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ser_data_i(sdata), .ser_clk_i(sclk), .ser_le_i(sle),
    .ref_ratio_o(ratio), .mod_sel_o(mod_sel), .pd_pol_o(pol), .mon_sel_o(mon),
    .ref_upd_o(ref_upd), .swallow_o(swl), .main_cnt_o(mainc),
    .div_upd_o(div_upd), .cfg_err_o(err)
  );

  always @(negedge clk) begin
    if (ref_upd) ref_cnt++;
    if (div_upd) div_cnt++;
    if (err)     err_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      wait_n(3);
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
      wait_n(4);
    end
  endtask

  task automatic pulse_le(input int hold);
    sle = 1'b1;
    wait_n(hold);
    sle = 1'b0;
    wait_n(6);
  endtask

  function automatic logic [17:0] ref_word(input logic [13:0] r, input logic m,
                                           input logic p, input logic s);
    return {s, p, m, r, 1'b1};
  endfunction

  function automatic logic [18:0] div_word(input logic [10:0] n, input logic [6:0] a);
    return {n, a, 1'b0};
  endfunction

  task automatic check_ref(input string req, input int r, input int m, input int p, input int s);
    check({req, " ratio"}, ratio, r);
    check({req, " modsel"}, mod_sel, m);
    check({req, " polarity"}, pol, p);
    check({req, " monsel"}, mon, s);
  endtask

  task automatic check_div(input string req, input int n, input int a);
    check({req, " main"}, mainc, n);
    check({req, " swallow"}, swl, a);
  endtask

  task automatic t_reset;
    check_ref("R9", 5, 0, 0, 0);
    check_div("R9", 5, 0);
    check("R9 strobes", {ref_upd, div_upd, err}, 0);
  endtask

  task automatic t_ref_load;
    int r0 = ref_cnt, d0 = div_cnt;
    send_bits(32'(ref_word(14'h2A5B, 1'b1, 1'b0, 1'b1)), 18);
    pulse_le(6);
    check_ref("R1 R2", 14'h2A5B, 1, 0, 1);
    check("R6 ref strobe", ref_cnt - r0, 1);
    check("R6 div strobe", div_cnt - d0, 0);
    check_div("R5", 5, 0);
  endtask

  task automatic t_div_load;
    int r0 = ref_cnt, d0 = div_cnt;
    send_bits(32'(div_word(11'h4C3, 7'h55)), 19);
    pulse_le(6);
    check_div("R3", 11'h4C3, 7'h55);
    check("R6 div strobe", div_cnt - d0, 1);
    check("R6 ref strobe", ref_cnt - r0, 0);
    check_ref("R5", 14'h2A5B, 1, 0, 1);
  endtask

  task automatic t_le_rules;
    int r0 = ref_cnt, d0 = div_cnt;
    send_bits(32'(ref_word(14'h0100, 1'b0, 1'b1, 1'b0)), 18);
    check_ref("R4 no strobe", 14'h2A5B, 1, 0, 1);
    pulse_le(40);
    check_ref("R4 held", 14'h0100, 0, 1, 0);
    check("R4 single transfer", ref_cnt - r0, 1);
    check("R4 div untouched", div_cnt - d0, 0);
  endtask

  task automatic t_ref_err;
    int r0 = ref_cnt, e0 = err_cnt;
    send_bits(32'(ref_word(14'd4, 1'b1, 1'b0, 1'b1)), 18);
    pulse_le(6);
    check_ref("R7 refused", 14'h0100, 0, 1, 0);
    check("R7 err pulse", err_cnt - e0, 1);
    check("R7 no strobe", ref_cnt - r0, 0);
    send_bits(32'(ref_word(14'd5, 1'b1, 1'b1, 1'b1)), 18);
    pulse_le(6);
    check_ref("R7 min", 5, 1, 1, 1);
    check("R7 min no err", err_cnt - e0, 1);
  endtask

  task automatic t_div_err;
    int d0 = div_cnt, e0 = err_cnt;
    send_bits(32'(div_word(11'd4, 7'h12)), 19);
    pulse_le(6);
    check_div("R8 refused", 11'h4C3, 7'h55);
    check("R8 err pulse", err_cnt - e0, 1);
    check("R8 no strobe", div_cnt - d0, 0);
    send_bits(32'(div_word(11'd5, 7'h12)), 19);
    pulse_le(6);
    check_div("R8 min", 5, 7'h12);
    check("R8 strobe", div_cnt - d0, 1);
  endtask

  task automatic t_extra_bits;
    send_bits({13'h1FFF, 1'b1, ref_word(14'h1357, 1'b0, 1'b0, 1'b1)}, 32);
    pulse_le(6);
    check_ref("R10 ref", 14'h1357, 0, 0, 1);
    send_bits({13'h1ABC, div_word(11'h321, 7'h0F)}, 32);
    pulse_le(6);
    check_div("R10 div", 11'h321, 7'h0F);
  endtask

  task automatic t_bounds;
    send_bits(32'(ref_word(14'h3FFF, 1'b0, 1'b0, 1'b0)), 18);
    pulse_le(6);
    check_ref("R11 ratio max", 16383, 0, 0, 0);
    send_bits(32'(div_word(11'h7FF, 7'h7F)), 19);
    pulse_le(6);
    check_div("R11 max", 2047, 127);
    send_bits(32'(div_word(11'd9, 7'h00)), 19);
    pulse_le(6);
    check_div("R11 swallow zero", 9, 0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_ref_load();
    t_div_load();
    t_le_rules();
    t_ref_err();
    t_div_err();
    t_extra_bits();
    t_bounds();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule